// File: doc/BRIEF.md
# Hardware Breakpoint Match and Resume-Skip Unit

This unit sits beside an instruction pipeline. It keeps a small table of breakpoint addresses and compares every program counter presented with a valid strobe against all of them at once. When the counter matches an entry, it raises a halt request in that same cycle and remembers the address. The next time that address comes up, the core resumes past the breakpoint: it is not stopped again, and the entry stays in the table. Entries are added and removed by writing an address to one of two write ports.

The second function covers resuming over a software breakpoint. The debugger first stores the address of the patched fetch and the original 32-bit instruction word. It then arms a one-shot skip. The next valid fetch from the stored address returns the original word in the low 32 bits instead of the breakpoint opcode, and the skip disarms itself. Fetches from any other address pass through unchanged.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the table is empty, the hit flag and the skip flag are clear, `haltReq` is low for every counter value, and `fetchDataOut` equals `fetchData`.
- R2: A cycle with `addWe` high loads `addData` into the lowest free slot at the clock edge. A later `pcValid` cycle whose `pcValue` equals any valid entry raises `haltReq` combinationally in that cycle.
- R3: When all `SLOTS` entries are valid, an add is ignored. Duplicate addresses may occupy separate slots.
- R4: A cycle with `delWe` high invalidates only the lowest-numbered valid slot equal to `delData`. If no slot matches, the table is unchanged, so a duplicate remaining in another slot still halts.
- R5: On a halt, the next clock edge sets `hwHit` and records `pcValue` as the hit address.
- R6: A `pcValid` cycle with `hwHit` set and `pcValue` equal to the recorded address does not halt, and it clears `hwHit`.
- R7: Any other `pcValid` cycle clears `hwHit` before matching. If that counter is in the table, it halts and sets the flag again.
- R8: With `pcValid` low, `haltReq` is low and `hwHit` holds its value.
- R9: `storeAddrWe` and `storeInstrWe` load the stored fetch address and the stored instruction word. `skipArm` sets the skip flag at the clock edge.
- R10: While the skip flag is set, a valid fetch whose `fetchAddr` equals the stored address returns `{fetchData[63:32], storedInstr}` in the same cycle and clears the flag. The next such fetch passes through unchanged.
- R11: While the skip flag is set, a fetch from any other address, or a cycle with `fetchValid` low, passes through unchanged and leaves the flag set.
- R12: Same-cycle ordering: the counter compare uses the table as it stood before that cycle's add or remove. A fetch in the cycle that `skipArm` is high sees the flag still clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addWe | input | 1 | Add-breakpoint write strobe |
| addData | input | AW | Address to add |
| delWe | input | 1 | Remove-breakpoint write strobe |
| delData | input | AW | Address to remove |
| storeAddrWe | input | 1 | Write strobe for the stored fetch address |
| storeAddrData | input | AW | Fetch address to patch |
| storeInstrWe | input | 1 | Write strobe for the stored instruction word |
| storeInstrData | input | 32 | Original instruction word |
| skipArm | input | 1 | Arms the one-shot fetch substitution |
| pcValid | input | 1 | Program counter check strobe |
| pcValue | input | AW | Program counter to check |
| fetchValid | input | 1 | Fetch data valid |
| fetchAddr | input | AW | Fetch address |
| fetchData | input | DW | Raw fetched data |
| haltReq | output | 1 | Halt request, combinational with `pcValid` |
| hwHit | output | 1 | Hardware breakpoint hit flag |
| fetchDataOut | output | DW | Fetched data after substitution |

## Verification
Two pairs of functions can land in the same cycle, and both are exercised. The first pair is a table write and a counter compare. The bench adds an address while presenting that same address on `pcValid`. It expects no halt in that cycle and a halt on the next presentation. The second pair is arming the skip and fetching. The bench raises `skipArm` together with a fetch from the stored address and expects raw data back in that cycle, then substituted data on the following fetch. Around these cases, the bench sweeps the counter over a full small address range, presenting each value twice. It judges every response against its own table and flag model, so the halt, the pass-over and the table ordering are all checked.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic loadEn;   // accept an add into the lowest free slot
    logic dropEn;   // invalidate the lowest matching slot
    logic hitLoad;  // record the current counter as the hit address
    logic patchEn;  // substitute the stored instruction word this cycle
  } bkptStrobes_t;

  localparam int INSTR_W = 32;
endpackage

// File: rtl/bkpt_table.sv
module bkpt_table
  import bkpt_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int AW    = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  bkptStrobes_t str,
  input  logic [AW-1:0] addData,
  input  logic [AW-1:0] delData,
  input  logic [AW-1:0] pcValue,
  output logic         full,
  output logic         delFound,
  output logic         pcInTable,
  output logic         pcIsRecorded
);
  logic [SLOTS-1:0]  slotValid;
  logic [AW-1:0]     slotAddr [SLOTS];
  logic [SLOTS-1:0]  pcMatch;
  logic [SLOTS-1:0]  delMatch;
  logic [SLOTS-1:0]  freeOh;
  logic [SLOTS-1:0]  delOh;
  logic [AW-1:0]     recAddr;

  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    assign pcMatch[i]  = slotValid[i] && (slotAddr[i] == pcValue);
    assign delMatch[i] = slotValid[i] && (slotAddr[i] == delData);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[i] <= 1'b0;
        slotAddr[i]  <= '0;
      end else begin
        if (str.dropEn && delOh[i]) slotValid[i] <= 1'b0;
        if (str.loadEn && freeOh[i]) begin
          slotValid[i] <= 1'b1;
          slotAddr[i]  <= addData;
        end
      end
    end
  end

  // Lowest-set-bit selection for the free slot and the slot to drop
  always_comb begin
    freeOh = (~slotValid) & ~((~slotValid) - SLOTS'(1));
    delOh  = delMatch & ~(delMatch - SLOTS'(1));
  end

  assign full      = &slotValid;
  assign delFound  = |delMatch;
  assign pcInTable = |pcMatch;

  always_ff @(posedge clk) begin
    if (!rstN)            recAddr <= '0;
    else if (str.hitLoad) recAddr <= pcValue;
  end

  assign pcIsRecorded = (recAddr == pcValue);
endmodule

// File: rtl/fetch_patch.sv
module fetch_patch
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  bkptStrobes_t  str,
  input  logic          storeAddrWe,
  input  logic [AW-1:0] storeAddrData,
  input  logic          storeInstrWe,
  input  logic [INSTR_W-1:0] storeInstrData,
  input  logic [AW-1:0] fetchAddr,
  input  logic [DW-1:0] fetchData,
  output logic          fetchAtStored,
  output logic [DW-1:0] fetchDataOut
);
  logic [AW-1:0]      storedAddr;
  logic [INSTR_W-1:0] storedInstr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedAddr  <= '0;
      storedInstr <= '0;
    end else begin
      if (storeAddrWe)  storedAddr  <= storeAddrData;
      if (storeInstrWe) storedInstr <= storeInstrData;
    end
  end

  assign fetchAtStored = (fetchAddr == storedAddr);

  generate
    if (DW > INSTR_W) begin : gWide
      assign fetchDataOut = str.patchEn ? {fetchData[DW-1:INSTR_W], storedInstr} : fetchData;
    end else begin : gNarrow
      assign fetchDataOut = str.patchEn ? storedInstr[DW-1:0] : fetchData;
    end
  endgenerate
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addWe,
  input  logic         delWe,
  input  logic         pcValid,
  input  logic         skipArm,
  input  logic         fetchValid,
  input  logic         full,
  input  logic         delFound,
  input  logic         pcInTable,
  input  logic         pcIsRecorded,
  input  logic         fetchAtStored,
  output bkptStrobes_t str,
  output logic         haltReq,
  output logic         hwHit,
  output logic         skipOn
);
  logic passOver;

  assign passOver = hwHit && pcIsRecorded;
  assign haltReq  = pcValid && !passOver && pcInTable;

  always_comb begin
    str.loadEn  = addWe && !full;
    str.dropEn  = delWe && delFound;
    str.hitLoad = haltReq;
    str.patchEn = skipOn && fetchValid && fetchAtStored;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        hwHit <= 1'b0;
    else if (pcValid) hwHit <= haltReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            skipOn <= 1'b0;
    else if (skipArm)     skipOn <= 1'b1;
    else if (str.patchEn) skipOn <= 1'b0;
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int AW    = 32,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addWe,
  input  logic [AW-1:0] addData,
  input  logic          delWe,
  input  logic [AW-1:0] delData,
  input  logic          storeAddrWe,
  input  logic [AW-1:0] storeAddrData,
  input  logic          storeInstrWe,
  input  logic [31:0]   storeInstrData,
  input  logic          skipArm,
  input  logic          pcValid,
  input  logic [AW-1:0] pcValue,
  input  logic          fetchValid,
  input  logic [AW-1:0] fetchAddr,
  input  logic [DW-1:0] fetchData,
  output logic          haltReq,
  output logic          hwHit,
  output logic [DW-1:0] fetchDataOut
);
  bkptStrobes_t str;
  logic full, delFound, pcInTable, pcIsRecorded, fetchAtStored, skipOn;

  bkpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addWe(addWe), .delWe(delWe), .pcValid(pcValid),
    .skipArm(skipArm), .fetchValid(fetchValid), .full(full), .delFound(delFound),
    .pcInTable(pcInTable), .pcIsRecorded(pcIsRecorded), .fetchAtStored(fetchAtStored),
    .str(str), .haltReq(haltReq), .hwHit(hwHit), .skipOn(skipOn)
  );

  bkpt_table #(.SLOTS(SLOTS), .AW(AW)) u_table (
    .clk(clk), .rstN(rstN), .str(str), .addData(addData), .delData(delData),
    .pcValue(pcValue), .full(full), .delFound(delFound), .pcInTable(pcInTable),
    .pcIsRecorded(pcIsRecorded)
  );

  fetch_patch #(.AW(AW), .DW(DW)) u_patch (
    .clk(clk), .rstN(rstN), .str(str), .storeAddrWe(storeAddrWe),
    .storeAddrData(storeAddrData), .storeInstrWe(storeInstrWe),
    .storeInstrData(storeInstrData), .fetchAddr(fetchAddr), .fetchData(fetchData),
    .fetchAtStored(fetchAtStored), .fetchDataOut(fetchDataOut)
  );
endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          pcValid,
  input logic          haltReq,
  input logic          hwHit,
  input logic          skipArm,
  input logic          skipOn,
  input logic          fetchValid,
  input logic [DW-1:0] fetchData,
  input logic [DW-1:0] fetchDataOut
);
  // R8
  halt_needs_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> pcValid);

  // R5
  hit_after_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> hwHit);

  // R6
  no_halt_clears_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcValid && !haltReq) |=> !hwHit);

  // R8
  idle_keeps_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pcValid |=> $stable(hwHit));

  // R11
  disarmed_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !skipOn |-> (fetchDataOut == fetchData));

  // R11
  no_fetch_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> (fetchDataOut == fetchData));

  // R10
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchDataOut[DW-1:32] == fetchData[DW-1:32]);

  // R10
  patch_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipOn && fetchValid && (fetchDataOut != fetchData) && !skipArm) |=> !skipOn);
endmodule

bind bkpt_unit bkpt_chk #(.DW(DW)) u_bkpt_chk (
  .clk(clk), .rstN(rstN), .pcValid(pcValid), .haltReq(haltReq), .hwHit(hwHit),
  .skipArm(skipArm), .skipOn(skipOn), .fetchValid(fetchValid),
  .fetchData(fetchData), .fetchDataOut(fetchDataOut)
);

// File: tb/test_bkpt_unit.sv
module test_bkpt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam int AW = 16;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addWe = 1'b0, delWe = 1'b0, storeAddrWe = 1'b0, storeInstrWe = 1'b0;
  logic skipArm = 1'b0, pcValid = 1'b0, fetchValid = 1'b0;
  logic [AW-1:0] addData = '0, delData = '0, storeAddrData = '0, pcValue = '0, fetchAddr = '0;
  logic [31:0] storeInstrData = '0;
  logic [DW-1:0] fetchData = '0;
  logic haltReq, hwHit;
  logic [DW-1:0] fetchDataOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // bench model
  bit            mValid [SLOTS];
  logic [AW-1:0] mAddr  [SLOTS];
  bit            mHit = 1'b0;
  logic [AW-1:0] mRec = '0;
  bit            mSkip = 1'b0;
  logic [AW-1:0] mStAddr = '0;
  logic [31:0]   mStInstr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_unit #(.SLOTS(SLOTS), .AW(AW), .DW(DW)) i_bkpt_unit (
    .clk(clk), .rstN(rstN), .addWe(addWe), .addData(addData), .delWe(delWe),
    .delData(delData), .storeAddrWe(storeAddrWe), .storeAddrData(storeAddrData),
    .storeInstrWe(storeInstrWe), .storeInstrData(storeInstrData), .skipArm(skipArm),
    .pcValid(pcValid), .pcValue(pcValue), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchData(fetchData), .haltReq(haltReq), .hwHit(hwHit), .fetchDataOut(fetchDataOut)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit inModel(input logic [AW-1:0] a);
    for (int i = 0; i < SLOTS; i++) if (mValid[i] && mAddr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void modelAdd(input logic [AW-1:0] a);
    for (int i = 0; i < SLOTS; i++) if (!mValid[i]) begin mValid[i] = 1'b1; mAddr[i] = a; return; end
  endfunction

  function automatic void modelDel(input logic [AW-1:0] a);
    for (int i = 0; i < SLOTS; i++) if (mValid[i] && mAddr[i] == a) begin mValid[i] = 1'b0; return; end
  endfunction

  // One counter check; halt judged mid-cycle, model updated at the edge
  task automatic pcCheck(input logic [AW-1:0] a, input string req);
    bit expHalt;
    @(negedge clk);
    pcValid = 1'b1; pcValue = a;
    #1;
    expHalt = inModel(a) && !(mHit && mRec == a);
    chk(req, DW'(haltReq), DW'(expHalt));
    @(posedge clk);
    mHit = expHalt;
    if (expHalt) mRec = a;
    @(negedge clk);
    pcValid = 1'b0;
    #1;
    chk("R5", DW'(hwHit), DW'(mHit));
  endtask

  task automatic doAdd(input logic [AW-1:0] a);
    @(negedge clk); addWe = 1'b1; addData = a;
    @(posedge clk); modelAdd(a);
    @(negedge clk); addWe = 1'b0;
  endtask

  task automatic doDel(input logic [AW-1:0] a);
    @(negedge clk); delWe = 1'b1; delData = a;
    @(posedge clk); modelDel(a);
    @(negedge clk); delWe = 1'b0;
  endtask

  task automatic fetchCheck(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    logic [DW-1:0] expOut;
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a; fetchData = d;
    #1;
    expOut = (mSkip && a == mStAddr) ? {d[DW-1:32], mStInstr} : d;
    chk(req, fetchDataOut, expOut);
    @(posedge clk);
    if (mSkip && a == mStAddr) mSkip = 1'b0;
    @(negedge clk); fetchValid = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk); skipArm = 1'b1;
    @(posedge clk); mSkip = 1'b1;
    @(negedge clk); skipArm = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin mValid[i] = 1'b0; mAddr[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: empty after reset
    for (int a = 0; a < 64; a++) pcCheck(AW'(a), "R1");
    fetchCheck(16'h0000, 64'h1111_2222_3333_4444, "R1");
    chk("R1", DW'(hwHit), 0);

    // R2, R3: fill with duplicates, then one add too many
    doAdd(5); doAdd(9); doAdd(9); doAdd(20); doAdd(33); doAdd(40); doAdd(41); doAdd(60);
    doAdd(61);  // R3: full, ignored
    for (int a = 0; a < 64; a++) begin
      pcCheck(AW'(a), "R2");
      pcCheck(AW'(a), "R6");
    end
    pcCheck(61, "R3");

    // R7: hit, then other address clears flag, then original halts again
    pcCheck(20, "R5");
    pcCheck(33, "R7");
    pcCheck(20, "R7");
    pcCheck(7, "R7");
    pcCheck(20, "R7");
    // R8: idle cycles keep the flag
    repeat (3) @(posedge clk);
    #1; chk("R8", DW'(hwHit), DW'(mHit));
    chk("R8", DW'(haltReq), 0);
    pcCheck(20, "R8");

    // R4: remove one duplicate, a missing address, then the other duplicate
    doDel(9);  pcCheck(9, "R4"); pcCheck(9, "R4");
    doDel(99); for (int a = 0; a < 64; a++) pcCheck(AW'(a), "R4");
    doDel(9);  pcCheck(9, "R4");
    doAdd(61); pcCheck(61, "R4");

    // R12: add and compare in the same cycle
    doDel(5);
    @(negedge clk);
    addWe = 1'b1; addData = 70; pcValid = 1'b1; pcValue = 70;
    #1; chk("R12", DW'(haltReq), 0);
    @(posedge clk); modelAdd(70); mHit = 1'b0;
    @(negedge clk); addWe = 1'b0; pcValid = 1'b0;
    pcCheck(70, "R12");
    // remove and compare in the same cycle
    @(negedge clk);
    delWe = 1'b1; delData = 40; pcValid = 1'b1; pcValue = 40;
    #1; chk("R12", DW'(haltReq), 1);
    @(posedge clk); modelDel(40); mHit = 1'b1; mRec = 40;
    @(negedge clk); delWe = 1'b0; pcValid = 1'b0;
    pcCheck(41, "R12");
    pcCheck(40, "R12");

    // R9: stored registers
    @(negedge clk);
    storeAddrWe = 1'b1; storeAddrData = 16'h0100;
    storeInstrWe = 1'b1; storeInstrData = 32'hDEAD_BEEF;
    @(posedge clk); mStAddr = 16'h0100; mStInstr = 32'hDEAD_BEEF;
    @(negedge clk); storeAddrWe = 1'b0; storeInstrWe = 1'b0;
    fetchCheck(16'h0100, 64'hAAAA_BBBB_0010_0073, "R9");  // not armed
    arm();
    fetchCheck(16'h0104, 64'h0123_4567_89AB_CDEF, "R11");
    repeat (2) @(posedge clk);  // fetchValid low, flag stays
    fetchCheck(16'h0100, 64'hAAAA_BBBB_0010_0073, "R10");
    fetchCheck(16'h0100, 64'hAAAA_BBBB_0010_0073, "R10");

    // R10, R11: sweep addresses and data patterns
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] d;
      d = {32'hC000_0000 + 32'(k * 3), 32'h0000_1000 + 32'(k * 17)};
      @(negedge clk);
      storeInstrWe = 1'b1; storeInstrData = 32'h5A00_0000 | 32'(k);
      storeAddrWe = 1'b1; storeAddrData = AW'(16'h0200 + k * 4);
      @(posedge clk); mStInstr = 32'h5A00_0000 | 32'(k); mStAddr = AW'(16'h0200 + k * 4);
      @(negedge clk); storeInstrWe = 1'b0; storeAddrWe = 1'b0;
      arm();
      fetchCheck(AW'(16'h0200 + k * 4 + 4), d, "R11");
      fetchCheck(AW'(16'h0200 + k * 4), d, "R10");
      fetchCheck(AW'(16'h0200 + k * 4), ~d, "R10");
    end

    // R12: arm and fetch in the same cycle
    @(negedge clk);
    skipArm = 1'b1; fetchValid = 1'b1; fetchAddr = mStAddr; fetchData = 64'hFFFF_0000_1234_5678;
    #1; chk("R12", fetchDataOut, 64'hFFFF_0000_1234_5678);
    @(posedge clk); mSkip = 1'b1;
    @(negedge clk); skipArm = 1'b0; fetchValid = 1'b0;
    fetchCheck(mStAddr, 64'hFFFF_0000_1234_5678, "R12");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule